// File: doc/BRIEF.md
# Pipeline Interlock Hazard Detector

This block produces the stall control for a five-stage in-order integer pipeline that has no operand bypassing. Each cycle it examines the 32-bit instruction in the decode stage and works out which source registers that instruction really reads. It also keeps a record of the destination register and write enable for each instruction now in execute, memory and writeback. When a genuine source operand matches a pending genuine write, it raises `stall`. The surrounding pipeline uses that signal to freeze the PC and the fetch/decode register, and the block itself sends a bubble into execute.

Read and write enables are worked out per instruction class. This keeps false dependences from stalling the pipeline:
- a write to register 0 is not a write;
- an operand field that the instruction does not read is not compared;
- jump-and-link instructions write the link register, whatever their register fields hold.

The per-stage destination record is exposed at the ports so that the writeback path and any observer can see what is in flight. The register file, ALU and memories are outside the block.

The decoder recognises these classes:
- NONE (bubble or unrecognised opcode)
- ALU (register-register)
- ALUI
- LOAD
- STORE
- BRZ (branch on zero)
- J
- JAL
- JR
- JALR

The block has no state machine. Its only state is the three-slot tracking chain. Each cycle that chain takes one of two transitions:
- **advance**: the decode record enters execute.
- **bubble**: a write-disabled slot enters execute.

In both transitions the older records shift toward writeback.

Top module: `hazard_interlock`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every tracked slot has write enable 0, and `stall` is 0.
- R2: Fields are op[31:26], rs[25:21], rt[20:16], rd[15:11] and func[5:0]. The destination is rd for R-type ALU ops (op 0x00 with func other than 0x08 or 0x09), rt for ALU-immediate (op 0x08 to 0x0F) and LW (op 0x23), and 31 for JAL (op 0x03) and JALR (op 0x00, func 0x09). A non-stalled valid decode instruction appears in the execute slot (`trk_dest[4:0]`, `trk_wen[0]`) one cycle later.
- R3: Write enable is (destination != 0) for ALU, ALU-immediate and LW, and 1 for JAL and JALR. It is 0 for SW (op 0x2B), branch-on-zero (op 0x04 or 0x05), J (op 0x02), JR (op 0x00, func 0x08) and unrecognised opcodes. A slot with write enable 0 records destination 0.
- R4: rs is read by ALU, ALU-immediate, LW, SW, branch-on-zero, JR and JALR. It is not read by J, JAL or unrecognised opcodes, whatever bits 25:21 hold.
- R5: rt is read only by R-type ALU ops and SW. ALU-immediate, loads and branches never stall on rt.
- R6: `stall` is 1 exactly when a read-enabled source equals the destination of an execute, memory or writeback slot whose write enable is 1.
- R7: In a stall cycle the execute slot receives a bubble (write enable 0, destination 0) at the next edge. Every cycle, memory takes the old execute slot and writeback takes the old memory slot.
- R8: A consumer placed immediately after its producer stalls for 3 cycles. With one independent instruction between them it stalls for 2 cycles, with two it stalls for 1, and with three it does not stall.
- R9: With `dec_valid` at 0, `stall` is 0 and a bubble enters execute.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all slots to bubbles |
| dec_instr | input | 32 | Instruction held in the decode stage |
| dec_valid | input | 1 | Decode stage holds a real instruction |
| stall | output | 1 | Freeze PC and fetch/decode; bubble into execute |
| trk_dest | output | 15 | Destination per slot: [4:0] execute, [9:5] memory, [14:10] writeback |
| trk_wen | output | 3 | Write enable per slot: bit 0 execute, 1 memory, 2 writeback |

## Verification
A wrong tracking slot is visible at the ports in two ways. It shows in `trk_dest`/`trk_wen` one cycle after the faulty capture. It then distorts `stall` for as long as the bad record stays in flight, which is at most three cycles before it leaves writeback. A decode error in the read or write enables shows at once as a missing or spurious `stall` for the instruction in decode, or as a wrong execute-slot record one cycle later. Back-to-back, distance-one and distance-two dependences measure the stall length directly, so a shortened chain or a dropped writeback compare changes the stall count.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int OP_W = 6;
    localparam int FN_W = 6;

    typedef enum logic [3:0] {
        CL_NONE,
        CL_ALU,
        CL_ALUI,
        CL_LOAD,
        CL_STORE,
        CL_BRZ,
        CL_J,
        CL_JAL,
        CL_JR,
        CL_JALR
    } op_class_e;

    localparam logic [OP_W-1:0] OPC_SPECIAL = 6'h00;
    localparam logic [OP_W-1:0] OPC_J       = 6'h02;
    localparam logic [OP_W-1:0] OPC_JAL     = 6'h03;
    localparam logic [OP_W-1:0] OPC_BRZ_EQ  = 6'h04;
    localparam logic [OP_W-1:0] OPC_BRZ_NE  = 6'h05;
    localparam logic [OP_W-1:0] OPC_LOAD    = 6'h23;
    localparam logic [OP_W-1:0] OPC_STORE   = 6'h2B;
    localparam logic [2:0]      OPC_ALUI_HI = 3'b001;
    localparam logic [FN_W-1:0] FN_JR       = 6'h08;
    localparam logic [FN_W-1:0] FN_JALR     = 6'h09;

    function automatic op_class_e classify(input logic [OP_W-1:0] op,
                                           input logic [FN_W-1:0] fn);
        op_class_e c;
        c = CL_NONE;
        if (op == OPC_SPECIAL) begin
            if (fn == FN_JR)
                c = CL_JR;
            else if (fn == FN_JALR)
                c = CL_JALR;
            else
                c = CL_ALU;
        end else if (op[OP_W-1:OP_W-3] == OPC_ALUI_HI) begin
            c = CL_ALUI;
        end else if (op == OPC_LOAD) begin
            c = CL_LOAD;
        end else if (op == OPC_STORE) begin
            c = CL_STORE;
        end else if (op == OPC_BRZ_EQ || op == OPC_BRZ_NE) begin
            c = CL_BRZ;
        end else if (op == OPC_J) begin
            c = CL_J;
        end else if (op == OPC_JAL) begin
            c = CL_JAL;
        end
        return c;
    endfunction

endpackage

// File: rtl/hz_decode.sv
module hz_decode
    import hz_pkg::*;
#(
    parameter int INSTR_W  = 32,
    parameter int REG_W    = 5,
    parameter int LINK_REG = 31
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic               valid,
    output logic [REG_W-1:0]   src1,
    output logic [REG_W-1:0]   src2,
    output logic               rd_en1,
    output logic               rd_en2,
    output logic [REG_W-1:0]   dest,
    output logic               wr_en
);

    localparam int OP_LSB = INSTR_W - OP_W;
    localparam int RS_LSB = OP_LSB - REG_W;
    localparam int RT_LSB = RS_LSB - REG_W;
    localparam int RD_LSB = RT_LSB - REG_W;
    localparam logic [REG_W-1:0] LINK = LINK_REG[REG_W-1:0];
    localparam logic [REG_W-1:0] ZERO = '0;

    logic [OP_W-1:0]  f_op;
    logic [FN_W-1:0]  f_fn;
    logic [REG_W-1:0] f_rs;
    logic [REG_W-1:0] f_rt;
    logic [REG_W-1:0] f_rd;
    logic             unused_shift_bits;
    op_class_e        cls;

    assign f_op = instr[INSTR_W-1:OP_LSB];
    assign f_rs = instr[OP_LSB-1:RS_LSB];
    assign f_rt = instr[RS_LSB-1:RT_LSB];
    assign f_rd = instr[RT_LSB-1:RD_LSB];
    assign f_fn = instr[FN_W-1:0];
    assign unused_shift_bits = ^instr[RD_LSB-1:FN_W];

    assign src1 = f_rs;
    assign src2 = f_rt;

    always_comb begin
        cls = valid ? classify(f_op, f_fn) : CL_NONE;
    end

    always_comb begin
        rd_en1 = 1'b0;
        rd_en2 = 1'b0;
        dest   = ZERO;
        wr_en  = 1'b0;
        unique case (cls)
            CL_ALU: begin
                rd_en1 = 1'b1;
                rd_en2 = 1'b1;
                dest   = f_rd;
                wr_en  = (f_rd != ZERO);
            end
            CL_ALUI, CL_LOAD: begin
                rd_en1 = 1'b1;
                dest   = f_rt;
                wr_en  = (f_rt != ZERO);
            end
            CL_STORE: begin
                rd_en1 = 1'b1;
                rd_en2 = 1'b1;
            end
            CL_BRZ, CL_JR: begin
                rd_en1 = 1'b1;
            end
            CL_JAL: begin
                dest  = LINK;
                wr_en = 1'b1;
            end
            CL_JALR: begin
                rd_en1 = 1'b1;
                dest   = LINK;
                wr_en  = 1'b1;
            end
            CL_J, CL_NONE: begin
                rd_en1 = 1'b0;
            end
            default: begin
                rd_en1 = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hz_track.sv
module hz_track #(
    parameter int DEPTH = 3,
    parameter int REG_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bubble,
    input  logic [REG_W-1:0]       in_dest,
    input  logic                   in_wen,
    output logic [DEPTH*REG_W-1:0] slot_dest,
    output logic [DEPTH-1:0]       slot_wen
);

    logic [REG_W-1:0] dest_q [DEPTH];
    logic             wen_q  [DEPTH];
    logic [REG_W-1:0] entry_dest;
    logic             entry_wen;

    always_comb begin
        entry_dest = bubble ? '0 : in_dest;
        entry_wen  = bubble ? 1'b0 : in_wen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dest_q[0] <= '0;
            wen_q[0]  <= 1'b0;
        end else begin
            dest_q[0] <= entry_dest;
            wen_q[0]  <= entry_wen;
        end
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dest_q[i] <= '0;
                wen_q[i]  <= 1'b0;
            end else begin
                dest_q[i] <= dest_q[i-1];
                wen_q[i]  <= wen_q[i-1];
            end
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_out
        always_comb begin
            slot_dest[i*REG_W +: REG_W] = dest_q[i];
            slot_wen[i]                 = wen_q[i];
        end
    end

endmodule

// File: rtl/hz_compare.sv
module hz_compare #(
    parameter int DEPTH = 3,
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0]       src1,
    input  logic [REG_W-1:0]       src2,
    input  logic                   rd_en1,
    input  logic                   rd_en2,
    input  logic [DEPTH*REG_W-1:0] slot_dest,
    input  logic [DEPTH-1:0]       slot_wen,
    output logic                   stall
);

    logic [DEPTH-1:0] hit1;
    logic [DEPTH-1:0] hit2;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        always_comb begin
            hit1[i] = slot_wen[i] && (slot_dest[i*REG_W +: REG_W] == src1);
            hit2[i] = slot_wen[i] && (slot_dest[i*REG_W +: REG_W] == src2);
        end
    end

    always_comb begin
        stall = (rd_en1 && (|hit1)) || (rd_en2 && (|hit2));
    end

endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock #(
    parameter int INSTR_W  = 32,
    parameter int REG_W    = 5,
    parameter int DEPTH    = 3,
    parameter int LINK_REG = 31
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [INSTR_W-1:0]     dec_instr,
    input  logic                   dec_valid,
    output logic                   stall,
    output logic [DEPTH*REG_W-1:0] trk_dest,
    output logic [DEPTH-1:0]       trk_wen
);

    logic [REG_W-1:0] d_src1;
    logic [REG_W-1:0] d_src2;
    logic             d_re1;
    logic             d_re2;
    logic [REG_W-1:0] d_dest;
    logic             d_wen;

    hz_decode #(
        .INSTR_W (INSTR_W),
        .REG_W   (REG_W),
        .LINK_REG(LINK_REG)
    ) u_decode (
        .instr (dec_instr),
        .valid (dec_valid),
        .src1  (d_src1),
        .src2  (d_src2),
        .rd_en1(d_re1),
        .rd_en2(d_re2),
        .dest  (d_dest),
        .wr_en (d_wen)
    );

    hz_compare #(
        .DEPTH(DEPTH),
        .REG_W(REG_W)
    ) u_compare (
        .src1     (d_src1),
        .src2     (d_src2),
        .rd_en1   (d_re1),
        .rd_en2   (d_re2),
        .slot_dest(trk_dest),
        .slot_wen (trk_wen),
        .stall    (stall)
    );

    hz_track #(
        .DEPTH(DEPTH),
        .REG_W(REG_W)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .bubble   (stall),
        .in_dest  (d_dest),
        .in_wen   (d_wen),
        .slot_dest(trk_dest),
        .slot_wen (trk_wen)
    );

endmodule

// File: rtl/hz_checker.sv
module hz_checker #(
    parameter int INSTR_W  = 32,
    parameter int REG_W    = 5,
    parameter int DEPTH    = 3,
    parameter int LINK_REG = 31
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [INSTR_W-1:0]     dec_instr,
    input logic                   dec_valid,
    input logic                   stall,
    input logic [DEPTH*REG_W-1:0] trk_dest,
    input logic [DEPTH-1:0]       trk_wen
);

    localparam int OP_LSB = INSTR_W - 6;
    localparam int RD_LSB = OP_LSB - 3*REG_W;
    localparam logic [REG_W-1:0] LINK = LINK_REG[REG_W-1:0];

    logic [5:0]       c_op;
    logic [5:0]       c_fn;
    logic [REG_W-1:0] c_rd;
    logic             unused_chk_bits;

    assign c_op = dec_instr[INSTR_W-1:OP_LSB];
    assign c_fn = dec_instr[5:0];
    assign c_rd = dec_instr[RD_LSB +: REG_W];
    assign unused_chk_bits = ^dec_instr;

    // R7: a stall sends a bubble into execute
    assert_bubble_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (!trk_wen[0] && trk_dest[REG_W-1:0] == '0));

    // R7: older slots shift toward writeback every cycle
    for (genvar i = 1; i < DEPTH; i++) begin : g_adv
        assert_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (trk_wen[i] == $past(trk_wen[i-1]) &&
                       trk_dest[i*REG_W +: REG_W] == $past(trk_dest[(i-1)*REG_W +: REG_W])));
    end

    // R9: an empty decode stage never stalls
    assert_idle_no_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !stall);

    // R6: a stall needs some pending write
    assert_stall_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (|trk_wen));

    // R2: JAL records the link register with write enable set
    assert_link_dest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !stall && c_op == 6'h03) |=> (trk_wen[0] && trk_dest[REG_W-1:0] == LINK));

    // R3: an ALU write to register 0 is not recorded as a write
    assert_r0_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !stall && c_op == 6'h00 && c_fn != 6'h09 && c_rd == '0) |=> !trk_wen[0]);

endmodule

bind hazard_interlock hz_checker #(
    .INSTR_W (INSTR_W),
    .REG_W   (REG_W),
    .DEPTH   (DEPTH),
    .LINK_REG(LINK_REG)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec_instr(dec_instr),
    .dec_valid(dec_valid),
    .stall    (stall),
    .trk_dest (trk_dest),
    .trk_wen  (trk_wen)
);

// File: tb/sim_hazard_interlock.sv
`timescale 1ns/1ps
module sim_hazard_interlock;

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] imm);
        return {op, imm};
    endfunction

    typedef struct packed {
        logic [31:0] prod;
        logic [31:0] cons;
        logic [4:0]  dest;
        logic        wen;
        logic        stl;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{enc_r(1, 2, 3, 6'h20),       enc_r(3, 0, 9, 6'h20),        5'd3,  1'b1, 1'b1},
        '{enc_r(1, 2, 0, 6'h20),       enc_r(0, 0, 9, 6'h20),        5'd0,  1'b0, 1'b0},
        '{enc_i(6'h08, 1, 5, 16'd4),   enc_i(6'h2B, 7, 5, 16'd0),    5'd5,  1'b1, 1'b1},
        '{enc_i(6'h23, 2, 6, 16'd8),   enc_i(6'h04, 6, 0, 16'd2),    5'd6,  1'b1, 1'b1},
        '{enc_i(6'h23, 2, 0, 16'd8),   enc_r(0, 0, 7, 6'h20),        5'd0,  1'b0, 1'b0},
        '{enc_i(6'h2B, 1, 8, 16'd0),   enc_r(8, 0, 9, 6'h20),        5'd0,  1'b0, 1'b0},
        '{enc_j(6'h03, 26'd100),       enc_r(31, 0, 0, 6'h08),       5'd31, 1'b1, 1'b1},
        '{enc_r(4, 0, 0, 6'h09),       enc_i(6'h08, 31, 2, 16'd1),   5'd31, 1'b1, 1'b1},
        '{enc_i(6'h08, 1, 9, 16'd3),   enc_i(6'h08, 2, 9, 16'd1),    5'd9,  1'b1, 1'b0},
        '{enc_i(6'h0D, 1, 10, 16'd3),  enc_j(6'h02, 26'd10 << 21),   5'd10, 1'b1, 1'b0},
        '{enc_r(1, 2, 11, 6'h20),      enc_j(6'h03, 26'd11 << 21),   5'd11, 1'b1, 1'b0},
        '{enc_j(6'h02, 26'd40),        enc_r(1, 2, 3, 6'h20),        5'd0,  1'b0, 1'b0},
        '{enc_r(1, 2, 12, 6'h20),      enc_i(6'h04, 1, 12, 16'd0),   5'd12, 1'b1, 1'b0},
        '{enc_r(1, 2, 13, 6'h22),      enc_r(5, 13, 9, 6'h20),       5'd13, 1'b1, 1'b1},
        '{enc_r(3, 0, 0, 6'h08),       enc_r(3, 0, 9, 6'h20),        5'd0,  1'b0, 1'b0}
    };

    logic        clk;
    logic        rst_n;
    logic [31:0] dec_instr;
    logic        dec_valid;
    logic        stall;
    logic [14:0] trk_dest;
    logic [2:0]  trk_wen;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    hazard_interlock u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec_instr(dec_instr),
        .dec_valid(dec_valid),
        .stall    (stall),
        .trk_dest (trk_dest),
        .trk_wen  (trk_wen)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drain();
        dec_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic dep_run(input logic [31:0] prod, input int gap, input logic [31:0] cons,
                           input logic [4:0] cdest, input int exp_stalls, input string tag);
        int cnt;
        @(negedge clk);
        dec_instr = prod;
        dec_valid = 1'b1;
        for (int k = 0; k < gap; k++) begin
            @(negedge clk);
            dec_instr = enc_i(6'h08, 0, 0, 16'd0);
        end
        @(negedge clk);
        dec_instr = cons;
        #1;
        cnt = 0;
        while (stall && cnt < 10) begin
            cnt++;
            @(negedge clk);
            #1;
        end
        chk(cnt == exp_stalls, tag, cnt, exp_stalls);
        @(negedge clk);
        chk(trk_wen[0] && trk_dest[4:0] == cdest, {tag, " consumer reaches execute (R2)"},
            int'(trk_dest[4:0]), int'(cdest));
        drain();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        dec_valid = 1'b1;
        dec_instr = enc_j(6'h03, 26'd5);
        repeat (3) @(negedge clk);
        chk(trk_wen == 3'b000, "R1 slots clear in reset", int'(trk_wen), 0);
        chk(stall == 1'b0, "R1 no stall in reset", int'(stall), 0);
        dec_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(trk_wen == 3'b000, "R1 slots clear after reset", int'(trk_wen), 0);

        // table walk: producer then consumer, one pair per entry (R2 R3 R4 R5 R6)
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            dec_instr = TBL[v].prod;
            dec_valid = 1'b1;
            @(negedge clk);
            chk(trk_dest[4:0] == TBL[v].dest && trk_wen[0] == TBL[v].wen,
                $sformatf("R2/R3 vector %0d execute slot", v),
                int'({trk_dest[4:0], trk_wen[0]}), int'({TBL[v].dest, TBL[v].wen}));
            dec_instr = TBL[v].cons;
            #1;
            chk(stall == TBL[v].stl, $sformatf("R4/R5/R6 vector %0d stall", v),
                int'(stall), int'(TBL[v].stl));
            dec_valid = 1'b0;
            repeat (4) @(negedge clk);
        end

        // R7: bubble injection and shifting during a stall
        @(negedge clk);
        dec_instr = enc_i(6'h08, 0, 1, 16'd10);
        dec_valid = 1'b1;
        @(negedge clk);
        dec_instr = enc_i(6'h08, 1, 4, 16'd17);
        #1;
        chk(stall == 1'b1, "R6 execute match stalls", int'(stall), 1);
        @(negedge clk);
        chk(trk_wen[0] == 1'b0 && trk_dest[4:0] == 5'd0, "R7 bubble in execute",
            int'(trk_wen[0]), 0);
        chk(trk_wen[1] && trk_dest[9:5] == 5'd1, "R7 producer in memory",
            int'(trk_dest[9:5]), 1);
        @(negedge clk);
        chk(trk_wen[2] && trk_dest[14:10] == 5'd1, "R7 producer in writeback",
            int'(trk_dest[14:10]), 1);
        chk(stall == 1'b1, "R6 writeback match stalls", int'(stall), 1);
        @(negedge clk);
        chk(stall == 1'b0, "R8 stall released after writeback", int'(stall), 0);
        drain();

        // R8: stall length against producer distance
        dep_run(enc_i(6'h08, 0, 1, 16'd10), 0, enc_i(6'h08, 1, 4, 16'd17), 5'd4, 3, "R8 distance 0");
        dep_run(enc_i(6'h08, 0, 1, 16'd10), 1, enc_i(6'h08, 1, 4, 16'd17), 5'd4, 2, "R8 distance 1");
        dep_run(enc_i(6'h08, 0, 1, 16'd10), 2, enc_i(6'h08, 1, 4, 16'd17), 5'd4, 1, "R8 distance 2");
        dep_run(enc_i(6'h08, 0, 1, 16'd10), 3, enc_i(6'h08, 1, 4, 16'd17), 5'd4, 0, "R8 distance 3");

        // R9: invalid decode does not stall and sends a bubble
        @(negedge clk);
        dec_instr = enc_r(1, 2, 7, 6'h20);
        dec_valid = 1'b1;
        @(negedge clk);
        dec_instr = enc_r(7, 7, 8, 6'h20);
        dec_valid = 1'b0;
        #1;
        chk(stall == 1'b0, "R9 no stall when decode empty", int'(stall), 0);
        @(negedge clk);
        chk(trk_wen[0] == 1'b0, "R9 bubble enters execute", int'(trk_wen[0]), 0);
        drain();

        // R1: reset in the middle of traffic clears every slot
        @(negedge clk);
        dec_instr = enc_j(6'h03, 26'd9);
        dec_valid = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(trk_wen == 3'b000, "R1 reset clears in-flight slots", int'(trk_wen), 0);
        @(negedge clk);
        dec_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(trk_wen == 3'b000 && stall == 1'b0, "R1 idle after second reset", int'(trk_wen), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule